// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a 15-bit virtual address into a 13-bit physical address with one level of paging. The upper five bits select a virtual page, the lower ten bits are the byte offset inside a 1 KB page. The block adds the page number, scaled by the two-byte entry size, to a base register, and reads that entry over a simple memory read port. The response is either the physical page number joined to the unchanged offset, or a fault code.

Software switches address spaces by writing the base register. A write takes effect for the next request the block accepts. A walk already in progress keeps the base value it was accepted with. The block handles one request at a time and waits as long as the memory needs before it acknowledges.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `mem_req` and `rsp_valid` are 0.
- R2: For an accepted request, `mem_addr` equals the base value plus twice the virtual page number, where the page number is `req_vaddr[14:10]`.
- R3: A permitted access to a valid entry returns `rsp_fault` = 00 and `rsp_paddr` = {entry bits 2:0, `req_vaddr[9:0]`}.
- R4: An entry with bit 15 (valid) equal to 0 returns `rsp_fault` = 01 (page fault) and `rsp_paddr` = 0, whatever its rights field holds.
- R5: For a valid entry, the rights field (entry bits 14:13) is checked against `req_acc` (00 read, 01 write, 10 execute). Rights 00 allow read only, 01 allow read and write, and 10 allow execute only. Any other combination returns `rsp_fault` = 10 (protection fault) and `rsp_paddr` = 0.
- R6: Rights value 11 and access code 11 always give a protection fault (10) on a valid entry.
- R7: `rsp_valid` is a one-cycle pulse. It arrives two cycles after the cycle in which `mem_ack` is seen. `req_ready` is 1 only while no walk is in progress, and a request presented while the block is busy is ignored.
- R8: A base-register write made during a walk does not change that walk's entry address. The next accepted request uses the new value.
- R9: `mem_req` and `mem_addr` stay steady until `mem_ack`, for any number of stall cycles, and the result is unchanged by the stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | 15 | Virtual address |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute |
| base_wr_en | input | 1 | Load the base register |
| base_wr_data | input | 16 | New page table base (byte address) |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 16 | Entry byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Entry word |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 13 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 ok, 01 page fault, 10 protection fault |

## Verification
On every cycle, the assertions check the following:
- the entry address against a shadow copy of the base register taken at acceptance;
- the read request staying steady through a stall;
- the one-cycle response pulse and when it arrives;
- the offset passing through unchanged;
- the physical address being zero on a fault.

Only the directed scenarios can show the rights table as a whole. They also cover the following:
- the physical page number taken from particular entries;
- a base switch between processes;
- a request ignored while the block is busy.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VPN_W       = 5,
  parameter int OFS_W       = 10,
  parameter int PPN_W       = 3,
  parameter int MA_W        = 16,
  parameter int PTE_W       = 16,
  parameter int ENTRY_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W+OFS_W-1:0] req_vaddr,
  input  logic [1:0]             req_acc,
  input  logic                   base_wr_en,
  input  logic [MA_W-1:0]        base_wr_data,
  output logic                   mem_req,
  output logic [MA_W-1:0]        mem_addr,
  input  logic                   mem_ack,
  input  logic [PTE_W-1:0]       mem_rdata,
  output logic                   rsp_valid,
  output logic [PPN_W+OFS_W-1:0] rsp_paddr,
  output logic [1:0]             rsp_fault
);
  localparam int VA_W  = VPN_W + OFS_W;
  localparam int PA_W  = PPN_W + OFS_W;
  localparam int V_BIT = PTE_W - 1;
  localparam int R_HI  = PTE_W - 2;
  localparam int R_LO  = PTE_W - 3;

  localparam logic [1:0] ACC_RD = 2'b00, ACC_WR = 2'b01, ACC_EX = 2'b10;
  localparam logic [1:0] RT_RO = 2'b00, RT_RW = 2'b01, RT_EX = 2'b10;
  localparam logic [1:0] F_OK = 2'b00, F_PAGE = 2'b01, F_PROT = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_RESPOND} state_t;

  state_t              state;
  logic [MA_W-1:0]     base_q;
  logic [MA_W-1:0]     walk_addr_q;
  logic [OFS_W-1:0]    ofs_q;
  logic [1:0]          acc_q;
  logic                pte_v_q;
  logic [1:0]          pte_r_q;
  logic [PPN_W-1:0]    pte_ppn_q;
  logic [PA_W-1:0]     paddr_q;
  logic [1:0]          fault_q;
  logic                accept;
  logic                permit;
  logic [1:0]          fault_n;
  logic [VPN_W-1:0]    vpn_in;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign vpn_in    = req_vaddr[VA_W-1:OFS_W];
  assign mem_req   = (state == S_FETCH);
  assign mem_addr  = walk_addr_q;
  assign rsp_valid = (state == S_RESPOND);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          base_q <= '0;
    else if (base_wr_en) base_q <= base_wr_data;

  always_comb begin
    case (pte_r_q)
      RT_RO:   permit = (acc_q == ACC_RD);
      RT_RW:   permit = (acc_q == ACC_RD) || (acc_q == ACC_WR);
      RT_EX:   permit = (acc_q == ACC_EX);
      default: permit = 1'b0;
    endcase
    if (!pte_v_q)     fault_n = F_PAGE;
    else if (!permit) fault_n = F_PROT;
    else              fault_n = F_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      walk_addr_q <= '0;
      ofs_q       <= '0;
      acc_q       <= '0;
      pte_v_q     <= 1'b0;
      pte_r_q     <= '0;
      pte_ppn_q   <= '0;
      paddr_q     <= '0;
      fault_q     <= F_OK;
    end else begin
      case (state)
        S_IDLE:
          if (accept) begin
            walk_addr_q <= base_q + MA_W'(vpn_in) * MA_W'(ENTRY_BYTES);
            ofs_q       <= req_vaddr[OFS_W-1:0];
            acc_q       <= req_acc;
            state       <= S_FETCH;
          end
        S_FETCH:
          if (mem_ack) begin
            pte_v_q   <= mem_rdata[V_BIT];
            pte_r_q   <= mem_rdata[R_HI:R_LO];
            pte_ppn_q <= mem_rdata[PPN_W-1:0];
            state     <= S_CHECK;
          end
        S_CHECK: begin
          fault_q <= fault_n;
          paddr_q <= (fault_n == F_OK) ? {pte_ppn_q, ofs_q} : '0;
          state   <= S_RESPOND;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VPN_W       = 5,
  parameter int OFS_W       = 10,
  parameter int PPN_W       = 3,
  parameter int MA_W        = 16,
  parameter int PTE_W       = 16,
  parameter int ENTRY_BYTES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [VPN_W+OFS_W-1:0] req_vaddr,
  input logic [1:0]             req_acc,
  input logic                   base_wr_en,
  input logic [MA_W-1:0]        base_wr_data,
  input logic                   mem_req,
  input logic [MA_W-1:0]        mem_addr,
  input logic                   mem_ack,
  input logic [PTE_W-1:0]       mem_rdata,
  input logic                   rsp_valid,
  input logic [PPN_W+OFS_W-1:0] rsp_paddr,
  input logic [1:0]             rsp_fault
);
  logic [MA_W-1:0]  shadow_base, exp_addr;
  logic [OFS_W-1:0] ofs_cap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shadow_base <= '0;
      exp_addr    <= '0;
      ofs_cap     <= '0;
    end else begin
      if (base_wr_en) shadow_base <= base_wr_data;
      if (req_valid && req_ready) begin
        exp_addr <= shadow_base + MA_W'(req_vaddr[VPN_W+OFS_W-1:OFS_W]) * MA_W'(ENTRY_BYTES);
        ofs_cap  <= req_vaddr[OFS_W-1:0];
      end
    end

  p_entry_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr == exp_addr);
  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b00) |-> rsp_paddr[OFS_W-1:0] == ofs_cap);
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);
  p_fault_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && req_ready));
  p_ack_to_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req && !rsp_valid) ##1 rsp_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind pt_walker pt_walker_chk #(
  .VPN_W(VPN_W), .OFS_W(OFS_W), .PPN_W(PPN_W), .MA_W(MA_W),
  .PTE_W(PTE_W), .ENTRY_BYTES(ENTRY_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_acc(req_acc), .base_wr_en(base_wr_en),
  .base_wr_data(base_wr_data), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [14:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        base_wr_en = 0;
  logic [15:0] base_wr_data = '0;
  logic        mem_req, mem_ack = 0;
  logic [15:0] mem_addr, mem_rdata = '0;
  logic        rsp_valid;
  logic [12:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0, n_bad = 0, stall = 0, wait_cnt = 0, fetch_cnt = 0;
  logic [15:0] last_ma = '0;
  logic [15:0] mem [256];

  always #2.5 clk = ~clk;

  pt_walker dut_i (.*);

  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 0;
    else if (mem_req) begin
      if (wait_cnt >= stall) begin
        mem_ack   <= 1;
        mem_rdata <= mem[mem_addr[8:1]];
        last_ma   <= mem_addr;
        fetch_cnt <= fetch_cnt + 1;
        wait_cnt  <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  function automatic logic [15:0] pte(bit v, logic [1:0] r, logic [2:0] ppn);
    return {v, r, 10'b0, ppn};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_rsp();
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic xlat(logic [14:0] va, logic [1:0] acc, logic [12:0] epa,
                      logic [1:0] ef, logic [15:0] ema, string req);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_fault == ef, req, "fault", rsp_fault, ef);
    chk(rsp_paddr == epa, req, "paddr", rsp_paddr, epa);
    chk(last_ma == ema, "R2", "entry addr", last_ma, ema);
  endtask

  task automatic set_base(logic [15:0] b);
    @(negedge clk); base_wr_en = 1; base_wr_data = b;
    @(negedge clk); base_wr_en = 0;
  endtask

  task automatic t_reset();
    chk(req_ready == 1 && mem_req == 0 && rsp_valid == 0, "R1", "reset outputs",
        {req_ready, mem_req, rsp_valid}, 3'b100);
  endtask

  task automatic t_basic();
    xlat({5'd3, 10'h155}, 2'b00, {3'd5, 10'h155}, 2'b00, 16'h0006, "R3");
    xlat({5'd31, 10'h3FF}, 2'b01, {3'd7, 10'h3FF}, 2'b00, 16'h003E, "R3");
    xlat({5'd0, 10'h000}, 2'b10, {3'd0, 10'h000}, 2'b00, 16'h0000, "R3");
  endtask

  task automatic t_invalid();
    xlat({5'd4, 10'h010}, 2'b00, 13'd0, 2'b01, 16'h0008, "R4");
    xlat({5'd5, 10'h011}, 2'b01, 13'd0, 2'b01, 16'h000A, "R4");
  endtask

  task automatic t_perm();
    for (int r = 0; r < 3; r++)
      for (int a = 0; a < 3; a++) begin
        bit ok;
        ok = (r == 0 && a == 0) || (r == 1 && a != 2) || (r == 2 && a == 2);
        mem[8 + r] = pte(1, 2'(r), 3'(r + 1));
        xlat({5'(8 + r), 10'h2A}, 2'(a), ok ? {3'(r + 1), 10'h2A} : 13'd0,
             ok ? 2'b00 : 2'b10, 16'(2 * (8 + r)), "R5");
      end
  endtask

  task automatic t_reserved();
    xlat({5'd12, 10'h001}, 2'b00, 13'd0, 2'b10, 16'h0018, "R6");
    xlat({5'd1, 10'h001}, 2'b11, 13'd0, 2'b10, 16'h0002, "R6");
  endtask

  task automatic t_stall();
    stall = 9;
    xlat({5'd3, 10'h0AA}, 2'b00, {3'd5, 10'h0AA}, 2'b00, 16'h0006, "R9");
    stall = 0;
  endtask

  task automatic t_base_switch();
    int f0;
    stall = 6;
    @(negedge clk);
    req_valid = 1; req_vaddr = {5'd3, 10'h077}; req_acc = 2'b00;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    base_wr_en = 1; base_wr_data = 16'h0080;
    @(negedge clk);
    base_wr_en = 0;
    while (!rsp_valid) @(negedge clk);
    chk(last_ma == 16'h0006, "R8", "in-flight addr", last_ma, 16'h0006);
    chk(rsp_paddr == {3'd5, 10'h077}, "R8", "in-flight paddr", rsp_paddr, {3'd5, 10'h077});
    stall = 0;
    f0 = fetch_cnt;
    xlat({5'd3, 10'h077}, 2'b00, {3'd2, 10'h077}, 2'b00, 16'h0086, "R8");
    chk(fetch_cnt == f0 + 1, "R8", "fetch count", fetch_cnt, f0 + 1);
    set_base(16'h0000);
  endtask

  task automatic t_busy();
    int f0;
    f0 = fetch_cnt;
    stall = 6;
    @(negedge clk);
    req_valid = 1; req_vaddr = {5'd31, 10'h100}; req_acc = 2'b00;
    @(negedge clk);
    req_vaddr = {5'd0, 10'h222};
    chk(req_ready == 0, "R7", "ready while busy", req_ready, 0);
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_paddr == {3'd7, 10'h100}, "R7", "first request kept", rsp_paddr, {3'd7, 10'h100});
    @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R7", "pulse width", {rsp_valid, req_ready}, 2'b01);
    chk(fetch_cnt == f0 + 1, "R7", "ignored request", fetch_cnt, f0 + 1);
    stall = 0;
  endtask

  initial begin
    foreach (mem[i]) mem[i] = 16'h0;
    mem[0]  = pte(1, 2'b10, 3'd0);
    mem[1]  = pte(1, 2'b01, 3'd4);
    mem[3]  = pte(1, 2'b00, 3'd5);
    mem[4]  = pte(0, 2'b01, 3'd6);
    mem[5]  = pte(0, 2'b11, 3'd6);
    mem[12] = pte(1, 2'b11, 3'd3);
    mem[31] = pte(1, 2'b01, 3'd7);
    mem[67] = pte(1, 2'b00, 3'd2);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_invalid();
    t_perm();
    t_reserved();
    t_stall();
    t_base_switch();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule